// File: doc/BRIEF.md
# UART Transmitter with RS-485 Driver-Enable Sequencing

This block serializes bytes onto an asynchronous line in 8N1 form and steers a half-duplex RS-485 transceiver. A producer offers bytes with a valid/ready handshake. Each accepted byte waits in a one-byte holding register until the shift engine takes it. The shift engine asserts the transceiver driver enable one full bit period before the first start bit of a burst. It keeps the enable high across frames that follow each other directly. It releases the enable exactly at the end of the final stop bit, or after a programmable trailing hold of one or two bit times. The local receiver enable is active low and is always the inverse of the driver enable, so the node never hears its own transmission.

Two status flags are kept apart. `buf_empty` means the holding register can take a new byte, and it rises while the previous byte is still being shifted. `tx_idle` means that no frame is on the line.

The controller is a state machine with the states IDLE, LEAD, START, DATA, STOP and HOLD. Its transitions are:
- IDLE→LEAD when a byte is held.
- LEAD→START at the end of the lead bit. The byte is loaded into the shifter on this transition.
- START→DATA at the end of the start bit.
- DATA→DATA after each data bit, and DATA→STOP after the eighth.
- STOP→START when a byte is held, loading it on this transition. Otherwise STOP→IDLE when the hold setting is 0, and STOP→HOLD when it is not.
- HOLD→START at the end of a hold bit when a byte is held. Otherwise HOLD→HOLD while hold bits remain, and HOLD→IDLE after the last one.

Top module: `u485_tx`

## Requirements
- R1: Each frame is one start bit at 0, then eight data bits with bit 0 first, then one stop bit at 1. `txd` is 1 whenever `drv_en` is 0.
- R2: A bit lasts `baud_div` clock cycles. Divisor values 0 and 1 act as 2.
- R3: When a byte is accepted while the block is idle, `drv_en` rises one cycle later. The start bit begins exactly one bit period after `drv_en` rises.
- R4: With `hold_bits`=0, `drv_en` falls on the same clock edge at which the stop bit of the last queued frame ends.
- R5: With `hold_bits`=1 or 2, `drv_en` falls that many bit periods after the last stop bit ends. The value 3 acts as 2.
- R6: `in_ready` equals `buf_empty`. The holding register is emptied on the edge at which the start bit of its byte begins. `buf_empty` is 0 in the cycle before that edge and 1 from that edge on.
- R7: `tx_idle` is 0 from the lead bit through the end of the stop bit. It is 1 in IDLE and during the trailing hold.
- R8: `rcv_en_n` is always the inverse of `drv_en`.
- R9: If a byte is held when a stop bit ends, its start bit begins on that same edge. `drv_en` stays 1 and no lead bit is inserted.
- R10: If a byte arrives during the trailing hold, its start bit begins at the next bit boundary of the hold. `drv_en` stays 1 and no lead bit is inserted.
- R11: While `rst_n` is 0, the following hold at the next edge: `txd`=1, `drv_en`=0, `rcv_en_n`=1, `buf_empty`=1, `tx_idle`=1, `in_ready`=1, and all counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous reset, active low |
| baud_div | input | 16 | clock cycles per bit; change only while idle |
| hold_bits | input | 2 | trailing driver-enable hold in bit times; change only while idle |
| in_valid | input | 1 | byte offered |
| in_data | input | 8 | byte to send |
| in_ready | output | 1 | holding register can take a byte |
| txd | output | 1 | serial line |
| drv_en | output | 1 | transceiver driver enable |
| rcv_en_n | output | 1 | transceiver receiver enable, active low |
| buf_empty | output | 1 | holding register empty |
| tx_idle | output | 1 | no frame on the line |

## Verification
Every result is timed from the register edges. `drv_en` rises one cycle after acceptance, and the start bit follows it after exactly P cycles. The stop bit ends 10·P cycles after the start bit begins. `drv_en` falls hold·P cycles after that, and the next start bit begins either on the stop-end edge or on a later multiple of P. The bench samples on the falling clock edge and counts those samples from the start-bit edge. It reads each bit at its midpoint and checks the flags on the exact sample where they are due: one sample before the load, the load sample, and the stop-end sample. Any start bit or enable edge that arrives early or late therefore shows up as a wrong count.

// File: rtl/u485_pkg.sv
package u485_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_HOLD
    } tx_state_e;

endpackage

// File: rtl/u485_bit_timer.sv
module u485_bit_timer #(
    parameter int DIV_W   = 16,
    parameter int MIN_PER = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             bit_end
);
    logic [DIV_W-1:0] per;
    logic [DIV_W-1:0] cnt_q;

    assign per     = (div < DIV_W'(MIN_PER)) ? DIV_W'(MIN_PER) : div;
    assign bit_end = run && (cnt_q == per - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (bit_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < per)); // R2

endmodule

// File: rtl/u485_hold_reg.sv
module u485_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data_q
);
    logic full_q;

    assign in_ready = !full_q;
    assign full     = full_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take) begin
            full_q <= 1'b0;
        end else if (in_valid && !full_q) begin
            full_q <= 1'b1;
            data_q <= in_data;
        end
    end

    AST_TAKE_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full_q); // R6
    AST_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !take) |=> (full_q && $stable(data_q))); // R6

endmodule

// File: rtl/u485_tx_fsm.sv
module u485_tx_fsm
    import u485_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HOLD_W   = 2,
    parameter int MAX_HOLD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_end,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [HOLD_W-1:0] hold_bits,
    output logic              take,
    output logic              run,
    output logic              txd,
    output logic              drv_en,
    output logic              tx_idle
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [IDX_W-1:0]  bidx_q;
    logic [HOLD_W-1:0] hcnt_q;
    logic [HOLD_W-1:0] hold_eff;

    assign hold_eff = (hold_bits > HOLD_W'(MAX_HOLD)) ? HOLD_W'(MAX_HOLD) : hold_bits;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (hold_full) state_d = ST_LEAD;
            ST_LEAD:  if (bit_end) state_d = ST_START;
            ST_START: if (bit_end) state_d = ST_DATA;
            ST_DATA:  if (bit_end && bidx_q == IDX_W'(DATA_W-1)) state_d = ST_STOP;
            ST_STOP: begin
                if (bit_end) begin
                    if (hold_full)               state_d = ST_START;
                    else if (hold_eff == '0)     state_d = ST_IDLE;
                    else                         state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (bit_end) begin
                    if (hold_full)                    state_d = ST_START;
                    else if (hcnt_q == HOLD_W'(1))    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign take = (state_q != ST_START) && (state_d == ST_START);
    assign run  = (state_q != ST_IDLE);

    // shift engine and hold counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bidx_q  <= '0;
            hcnt_q  <= '0;
        end else begin
            if (take) begin
                shreg_q <= hold_data;
                bidx_q  <= '0;
            end else if (state_q == ST_DATA && bit_end) begin
                shreg_q <= shreg_q >> 1;
                bidx_q  <= bidx_q + IDX_W'(1);
            end
            if (state_q == ST_STOP && bit_end) begin
                hcnt_q <= hold_eff;
            end else if (state_q == ST_HOLD && bit_end) begin
                hcnt_q <= hcnt_q - HOLD_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        txd     = 1'b1;
        drv_en  = 1'b1;
        tx_idle = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                drv_en  = 1'b0;
                tx_idle = 1'b1;
            end
            ST_LEAD:  ;
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg_q[0];
            ST_STOP:  ;
            ST_HOLD:  tx_idle = 1'b1;
            default: begin
                drv_en  = 1'b0;
                tx_idle = 1'b1;
            end
        endcase
    end

    AST_LEAD_THEN_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD && bit_end) |=> (!txd && drv_en)); // R3
    AST_LINE_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |-> txd); // R1
    AST_DE_FALL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> $past(bit_end)); // R4
    AST_NO_LEAD_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && bit_end && hold_full) |=> (!txd && drv_en)); // R9
    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (hcnt_q != '0 && hcnt_q <= HOLD_W'(MAX_HOLD))); // R5

endmodule

// File: rtl/u485_tx.sv
module u485_tx #(
    parameter int DATA_W   = 8,
    parameter int DIV_W    = 16,
    parameter int HOLD_W   = 2,
    parameter int MAX_HOLD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [HOLD_W-1:0] hold_bits,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              txd,
    output logic              drv_en,
    output logic              rcv_en_n,
    output logic              buf_empty,
    output logic              tx_idle
);
    logic              take;
    logic              run;
    logic              bit_end;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;

    u485_bit_timer #(.DIV_W(DIV_W), .MIN_PER(2)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div     (baud_div),
        .bit_end (bit_end)
    );

    u485_hold_reg #(.DATA_W(DATA_W)) hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .take     (take),
        .full     (hold_full),
        .data_q   (hold_data)
    );

    u485_tx_fsm #(.DATA_W(DATA_W), .HOLD_W(HOLD_W), .MAX_HOLD(MAX_HOLD)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_end   (bit_end),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .hold_bits (hold_bits),
        .take      (take),
        .run       (run),
        .txd       (txd),
        .drv_en    (drv_en),
        .tx_idle   (tx_idle)
    );

    assign rcv_en_n  = !drv_en;
    assign buf_empty = !hold_full;

    AST_IDLE_FLAG_DE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_idle |-> drv_en); // R7
    AST_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> !rcv_en_n); // R8
    AST_READY_IS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == buf_empty); // R6

endmodule

// File: tb/u485_tx_tb_top.sv
module u485_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'd4;
    logic [1:0]  hold_bits = 2'd0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready, txd, drv_en, rcv_en_n, buf_empty, tx_idle;

    always #2.5 clk = ~clk;

    u485_tx dut_i (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .hold_bits(hold_bits),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .txd(txd), .drv_en(drv_en), .rcv_en_n(rcv_en_n),
        .buf_empty(buf_empty), .tx_idle(tx_idle)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int per_e = 4;
    int hold_e = 0;
    logic [7:0] expq [0:1023];
    int qw = 0;
    int qr = 0;
    int mc = 0;
    logic be_prev = 1'b1;
    int last_burst = 0;
    int last_gap = -1;

    function automatic int eff_per(input int d);
        return (d < 2) ? 2 : d;
    endfunction

    function automatic int eff_hold(input int h);
        return (h > 2) ? 2 : h;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // monitor sampling on the falling edge
    task automatic tick;
        be_prev = buf_empty;
        @(negedge clk);
        mc++;
    endtask

    initial begin : monitor
        int rise, s, prev_end;
        bit first;
        logic [7:0] b;
        @(posedge rst_n);
        forever begin
            tick();
            if (!drv_en) begin
                if (txd !== 1'b1 || rcv_en_n !== 1'b1)
                    chk(1'b0, "R1/R8", "idle line or receiver enable", {txd, rcv_en_n}, 3);
                continue;
            end
            rise = mc;
            first = 1'b1;
            prev_end = 0;
            forever begin
                while (drv_en && txd) begin
                    if (rcv_en_n !== 1'b0) chk(1'b0, "R8", "rcv_en_n while driving", rcv_en_n, 0);
                    tick();
                end
                if (!drv_en) begin
                    chk(!first, "R3", "enable dropped with no frame", 0, 1);
                    if (!first)
                        chk(mc - prev_end == hold_e * per_e, (hold_e == 0) ? "R4" : "R5",
                            "enable release delay", mc - prev_end, hold_e * per_e);
                    chk(tx_idle == 1'b1, "R7", "tx_idle after release", tx_idle, 1);
                    last_burst = mc - rise;
                    break;
                end
                s = mc;
                if (first) begin
                    chk(s - rise == per_e, "R3", "lead before start", s - rise, per_e);
                end else begin
                    last_gap = s - prev_end;
                    chk((last_gap % per_e == 0) && (last_gap <= hold_e * per_e),
                        (last_gap == 0) ? "R9" : "R10", "next start alignment", last_gap, 0);
                end
                first = 1'b0;
                chk(buf_empty == 1'b1 && be_prev == 1'b0, "R6", "empty flag at load",
                    {be_prev, buf_empty}, 1);
                repeat (per_e / 2) tick();
                chk(txd == 1'b0, "R1", "start bit level", txd, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (per_e) tick();
                    b[i] = txd;
                end
                repeat (per_e) tick();
                chk(txd == 1'b1 && tx_idle == 1'b0 && drv_en == 1'b1, "R1",
                    "stop bit with busy flag", {txd, tx_idle, drv_en}, 5);
                if (qr < qw) begin
                    chk(b == expq[qr], "R1", "decoded byte", b, expq[qr]);
                    qr++;
                end else begin
                    chk(1'b0, "R1", "unexpected frame", b, 0);
                end
                repeat (per_e - per_e / 2) tick();
                prev_end = mc;
                chk(tx_idle == txd, "R7", "tx_idle at stop end", tx_idle, txd);
            end
        end
    end

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data = d;
        while (!in_ready) @(negedge clk);
        expq[qw] = d;
        qw++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_quiet;
        int q;
        q = 0;
        while (q < 3) begin
            @(negedge clk);
            if (!drv_en && buf_empty && tx_idle && !in_valid) q++;
            else q = 0;
        end
    endtask

    task automatic setup(input int d, input int h);
        baud_div = 16'(d);
        hold_bits = 2'(h);
        per_e = eff_per(d);
        hold_e = eff_hold(h);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        chk(1'b0, "ALL", "watchdog expired", 0, 1);
        report();
    end

    initial begin : main
        int seg_n, nb, gap;
        void'($urandom(32'h5EED_0485));
        // R11 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(txd == 1 && drv_en == 0 && rcv_en_n == 1, "R11", "line outputs in reset",
            {txd, drv_en, rcv_en_n}, 5);
        chk(buf_empty == 1 && tx_idle == 1 && in_ready == 1, "R11", "flags in reset",
            {buf_empty, tx_idle, in_ready}, 7);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(drv_en == 0 && txd == 1, "R11", "quiet after reset", {drv_en, txd}, 1);

        // R3/R4 single byte, hold 0
        setup(4, 0);
        send_byte(8'hA5);
        wait_quiet();
        chk(last_burst == 11 * 4, "R4", "single frame enable length", last_burst, 44);

        // R9 back-to-back
        send_byte(8'h3C);
        send_byte(8'hC3);
        wait_quiet();
        chk(last_burst == 21 * 4, "R9", "two-frame burst length", last_burst, 84);
        chk(last_gap == 0, "R9", "no gap between frames", last_gap, 0);

        // R10 byte written during hold
        setup(4, 2);
        send_byte(8'h81);
        while (!(tx_idle && drv_en)) @(negedge clk);
        send_byte(8'h7E);
        wait_quiet();
        chk(last_gap == 4, "R10", "start at next hold boundary", last_gap, 4);

        // R5 hold 3 behaves as 2, R2 divisor 0 behaves as 2
        setup(0, 3);
        send_byte(8'h01);
        wait_quiet();
        chk(last_burst == 2 + 20 + 4, "R5", "hold of 3 capped", last_burst, 26);
        setup(1, 1);
        send_byte(8'hFE);
        wait_quiet();
        chk(last_burst == 2 + 20 + 2, "R2", "divisor 1 acts as 2", last_burst, 24);

        // constrained random segments
        for (int seg = 0; seg < 24; seg++) begin
            seg_n = 2 + int'($urandom_range(0, 7));
            setup(seg_n, int'($urandom_range(0, 3)));
            nb = 1 + int'($urandom_range(0, 4));
            for (int k = 0; k < nb; k++) begin
                send_byte(8'($urandom));
                gap = int'($urandom_range(0, 14 * seg_n));
                repeat (gap) @(negedge clk);
            end
            wait_quiet();
        end
        chk(qr == qw, "R1", "all bytes sent", qr, qw);
        report();
    end
endmodule